// File: doc/BRIEF.md
# Fractional Phase Accumulator with Feedback Pulse Deletion

This block is the fractional-division core of a phase-locked loop that outputs the sum of two input frequencies. On each reference tick it adds an unsigned fractional increment to an N-bit phase register. The increment is the ratio of the secondary frequency to the reference frequency, scaled so that 2^N stands for one cycle. The register wraps modulo one cycle. Every wrap marks one extra output period that the loop must absorb.

Each wrap does two things. It pulses a carry output, and it arms a pulse remover. The pulse remover deletes exactly one whole pulse from the feedback pulse stream before that stream reaches the phase comparator. The residual phase held in the register is driven out so that the surrounding loop can scale it and add it to the phase error. This keeps the combined error constant at lock.

The remover holds at most one pending deletion. If a wrap arrives while a deletion is still pending and that pending deletion is not consumed in the same cycle, a sticky overflow flag is set. A synchronous reset clears all state.

Top module: `frac_carry_deleter`

## Requirements
- R1: While and right after synchronous reset, residual reads 0, carry and overflow read 0, no deletion is pending, and fbPulseOut equals fbPulseIn.
- R2: On a clock edge where refTick is 1, residual becomes (residual + increment) mod 2^N. Without refTick, residual holds its value.
- R3: carry is 1 for exactly the cycle after a tick whose unwrapped sum residual + increment is at least 2^N. It is 0 in every other cycle.
- R4: After a wrap, the next feedback pulse, counted from its rising edge, is removed completely: fbPulseOut stays 0 for its whole high phase. The pending deletion then clears.
- R5: With no deletion pending, fbPulseOut follows fbPulseIn in the same cycle.
- R6: A wrap that occurs while a deletion is pending, and is not consumed in that cycle, sets overflow. overflow stays 1 until reset.
- R7: A wrap in the same cycle as the rising edge that consumes a pending deletion re-arms the remover without setting overflow, so the following pulse is also removed.
- R8: With increment = L for a constant L, the accumulator wraps floor(k·L/2^N) times in k ticks. For example, 16384 wraps once every 4 ticks, and 19661 wraps 3 times in 10 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refTick | input | 1 | One-cycle strobe per reference period |
| increment | input | N | Fractional step; 2^N represents one cycle |
| fbPulseIn | input | 1 | Feedback pulse stream from the output divider |
| fbPulseOut | output | 1 | Feedback stream with removed pulses masked |
| residual | output | N | Accumulated fractional phase, used for error compensation |
| carry | output | 1 | One-cycle wrap indication |
| overflow | output | 1 | Sticky flag: wrap arrived while a deletion was pending |

## Verification
The bench targets the wrap boundary. It checks a sum that lands exactly on 2^N and one that stops one LSB short; a design with an off-by-one compare would miss the carry, or raise it where it should not. It removes a pulse that stays high for several cycles, which catches a remover that masks only the edge cycle and lets the rest of the pulse through. It also drives a wrap in the same cycle as the consuming edge, and a second wrap with nothing consuming the first. A design with the wrong priority would either flag a false overflow or drop the re-armed deletion.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accEn;
    logic accClear;
  } fcdStrobe_t;
endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  fcdStrobe_t   strobe,
  input  logic [N-1:0] increment,
  output logic [N-1:0] accValue,
  output logic         wrapNow,
  output logic         carryReg
);
  localparam int SW = N + 1;

  logic [SW-1:0] sumExt;

  always_comb begin
    sumExt  = {1'b0, accValue} + {1'b0, increment};
    wrapNow = strobe.accEn && sumExt[N];
  end

  always_ff @(posedge clk) begin
    if (strobe.accClear) begin
      accValue <= '0;
      carryReg <= 1'b0;
    end else begin
      carryReg <= wrapNow;
      if (strobe.accEn) accValue <= sumExt[N-1:0];
    end
  end
endmodule

// File: rtl/fcd_control.sv
module fcd_control
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       refTick,
  input  logic       wrapNow,
  input  logic       fbPulseIn,
  output fcdStrobe_t strobe,
  output logic       fbPulseOut,
  output logic       overflow
);
  logic pending;
  logic masking;
  logic prevIn;
  logic riseNow;
  logic consume;

  always_comb begin
    strobe.accEn    = refTick && !rst;
    strobe.accClear = rst;
    riseNow         = fbPulseIn && !prevIn;
    consume         = pending && riseNow;
    fbPulseOut      = fbPulseIn && !(masking || consume);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      masking  <= 1'b0;
      prevIn   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      prevIn <= fbPulseIn;
      // hold the mask for the whole high phase of a removed pulse
      if (consume)         masking <= 1'b1;
      else if (!fbPulseIn) masking <= 1'b0;
      // a wrap re-arms; a consumed edge clears unless re-armed
      if (wrapNow)      pending <= 1'b1;
      else if (consume) pending <= 1'b0;
      if (wrapNow && pending && !consume) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/frac_carry_deleter.sv
module frac_carry_deleter
  import fcd_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         refTick,
  input  logic [N-1:0] increment,
  input  logic         fbPulseIn,
  output logic         fbPulseOut,
  output logic [N-1:0] residual,
  output logic         carry,
  output logic         overflow
);
  fcdStrobe_t strobe;
  logic       wrapNow;

  fcd_control uCtrl (
    .clk        (clk),
    .rst        (rst),
    .refTick    (refTick),
    .wrapNow    (wrapNow),
    .fbPulseIn  (fbPulseIn),
    .strobe     (strobe),
    .fbPulseOut (fbPulseOut),
    .overflow   (overflow)
  );

  fcd_datapath #(.N(N)) uDp (
    .clk       (clk),
    .strobe    (strobe),
    .increment (increment),
    .accValue  (residual),
    .wrapNow   (wrapNow),
    .carryReg  (carry)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         refTick,
  input logic [N-1:0] increment,
  input logic         fbPulseIn,
  input logic         fbPulseOut,
  input logic [N-1:0] residual,
  input logic         carry,
  input logic         overflow
);
  AST_CARRY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (carry && !$past(rst)) |-> $past(refTick)); // R3
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(refTick)) |-> $stable(residual)); // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(refTick)) |-> (residual == N'($past(residual) + $past(increment)))); // R2
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R6
  AST_OUT_WITHIN_IN: assert property (@(posedge clk) disable iff (rst)
    fbPulseOut |-> fbPulseIn); // R4
endmodule

bind frac_carry_deleter fcd_checker #(.N(N)) uChk (
  .clk        (clk),
  .rst        (rst),
  .refTick    (refTick),
  .increment  (increment),
  .fbPulseIn  (fbPulseIn),
  .fbPulseOut (fbPulseOut),
  .residual   (residual),
  .carry      (carry),
  .overflow   (overflow)
);

// File: tb/sim_frac_carry_deleter.sv
`timescale 1ns/1ps
module sim_frac_carry_deleter;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refTick = 1'b0;
  logic [N-1:0] increment = '0;
  logic fbPulseIn = 1'b0;
  logic fbPulseOut;
  logic [N-1:0] residual;
  logic carry;
  logic overflow;

  int checks = 0;
  int errors = 0;
  int wraps  = 0;
  logic [N-1:0] modelAcc = '0;

  typedef struct { logic [N-1:0] acc; logic cy; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  frac_carry_deleter #(.N(N)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one tick, expected result pushed to the scoreboard
  task automatic tick(input logic [N-1:0] inc);
    logic [N:0] s;
    @(negedge clk);
    refTick = 1'b1; increment = inc;
    s = {1'b0, modelAcc} + {1'b0, inc};
    modelAcc = s[N-1:0];
    if (s[N]) wraps++;
    expQ.push_back('{acc: s[N-1:0], cy: s[N]});
    @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; refTick = 1'b0; fbPulseIn = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    modelAcc = '0;
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(posedge clk);
      begin
        logic t;
        t = refTick && !rst;
        #1;
        if (t) begin
          expItem_t e;
          if (expQ.size() == 0) check("R2 queue", 1, 0);
          else begin
            e = expQ.pop_front();
            check("R2 residual", residual, e.acc);
            check("R3 carry", carry, e.cy);
          end
        end else if (!rst) begin
          check("R3 carry idle", carry, 0);
        end
      end
    end
  end

  // drive a feedback pulse of hiCycles and check that each cycle passes or is removed
  task automatic pulse(input string req, input int hiCycles, input logic expPass);
    @(negedge clk); fbPulseIn = 1'b1;
    for (int i = 0; i < hiCycles; i++) begin
      #1 check(req, fbPulseOut, expPass);
      @(negedge clk);
    end
    fbPulseIn = 1'b0;
    #1 check(req, fbPulseOut, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    check("R1 residual", residual, 0);
    check("R1 carry", carry, 0);
    check("R1 overflow", overflow, 0);
    rst = 1'b0;
    pulse("R1 passthrough", 2, 1);
    pulse("R5 passthrough", 3, 1);

    // R2 hold without tick
    repeat (3) @(negedge clk);
    #1 check("R2 hold", residual, 0);

    // R3 boundary: one short, then exactly 2^N
    tick(16'hFFFF);
    tick(16'h0000);
    tick(16'h0001);
    check("R6 no overflow", overflow, 0);
    // R4: the armed deletion removes a 3-cycle pulse, the next one passes
    pulse("R4 removed", 3, 0);
    pulse("R4 next passes", 2, 1);

    // R6: two wraps, no pulse between
    tick(16'h8000); tick(16'h8000);
    tick(16'h8000); tick(16'h8000);
    @(negedge clk); #1 check("R6 overflow set", overflow, 1);
    repeat (4) @(negedge clk);
    #1 check("R6 sticky", overflow, 1);
    pulse("R6 pending removed", 1, 0);
    pulse("R6 then passes", 1, 1);

    doReset();
    #1 check("R1 overflow cleared", overflow, 0);
    check("R1 residual cleared", residual, 0);
    pulse("R1 no pending after reset", 1, 1);

    // R7: wrap in the same cycle as the consuming edge
    tick(16'hC000); tick(16'hC000);      // one wrap, residual 0x8000
    @(negedge clk);
    refTick = 1'b1; increment = 16'h8000; fbPulseIn = 1'b1;
    expQ.push_back('{acc: 16'h0000, cy: 1'b1});
    modelAcc = 16'h0000;
    #1 check("R7 edge removed", fbPulseOut, 0);
    @(negedge clk); refTick = 1'b0;
    #1 check("R7 mask held", fbPulseOut, 0);
    @(negedge clk); fbPulseIn = 1'b0;
    #1 check("R7 no overflow", overflow, 0);
    pulse("R7 rearmed removal", 2, 0);
    pulse("R7 then passes", 2, 1);
    check("R7 overflow still clear", overflow, 0);

    // R8: wrap counts
    doReset();
    wraps = 0;
    for (int k = 0; k < 8; k++) tick(16'd16384);
    check("R8 quarter wraps", wraps, 2);
    doReset();
    wraps = 0;
    for (int k = 0; k < 10; k++) tick(16'd19661);
    check("R8 three in ten", wraps, 3);
    repeat (2) @(negedge clk);
    check("R8 queue drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule